// File: doc/BRIEF.md
# Shadow-Memory Store/Recall Sequencer

A synthesizable behavioural model of a byte-wide static RAM in which every location has a nonvolatile shadow copy. In normal operation the array is read and written through a simple chip-enable / output-enable / write-enable port, sampled on a system clock, with one access per cycle. On request the whole array is copied in one step to the shadow array (STORE) or back from it (RECALL). While a copy is running, the user port is locked out.

A transfer can be requested in four ways. A power-fail input starts a STORE. A rising power-good input starts a RECALL. An active-low store-request pin starts a STORE. A software unlock sequence also works: five reads at fixed addresses followed by a sixth read whose address selects STORE or RECALL. A RECALL first clears the array and then loads it from the shadow copy. The shadow copy itself is never altered by a RECALL. Transfer durations are parameters counted in clock cycles. The default geometry is 256 x 8 so that elaboration stays small; setting `ADDR_W` to 15 gives the full 32K x 8 array.

Top module: `nvsram_shadow`

## Requirements
- R1: In idle, a cycle with ce_ni=0, we_ni=1, oe_ni=0 drives data_o with the byte at addr_i and sets data_oe_o=1 in the same cycle. A cycle with ce_ni=0, we_ni=0 writes data_i to addr_i at the clock edge. With oe_ni=1 or ce_ni=1, data_oe_o stays 0.
- R2: Five consecutive idle reads at addresses 0x0E, 0x38, 0xC7, 0x1F, 0xE0, followed by a sixth read, start a STORE at the next edge if the sixth address is 0x3C, or a RECALL if it is 0x4C. A STORE copies every array byte into the shadow array.
- R3: A write, or a read at an address that does not match the next expected step, between steps of the sequence aborts it. No transfer starts, and the shadow array keeps its contents. Cycles with ce_ni=1 do not count as accesses.
- R4: A RECALL leaves every array byte equal to its shadow byte. It never modifies the shadow array, and repeating it gives the same result.
- R5: A rising edge of pwr_good_i starts a RECALL. This includes pwr_good_i already high when reset is released.
- R6: pwr_fail_i high in an idle cycle starts a STORE at the next edge.
- R7: store_n_i low in an idle cycle starts a STORE at the next edge.
- R8: When several requests fall in the same idle cycle, the priority is pwr_fail_i, then the power-good rise, then store_n_i, then the software sequence. A write in a cycle that starts a transfer is dropped.
- R9: While a transfer runs, data_oe_o is 0, writes are dropped, reads do not advance the sequence, and busy_no is 0.
- R10: A STORE keeps the block busy for exactly STORE_CYCLES cycles (default 40). A RECALL keeps it busy for exactly RECALL_CYCLES cycles (default 12).
- R11: status_o encodes 0 as idle, 1 as store-busy and 2 as recall-busy. After reset status_o is 0 and busy_no is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| ce_ni | input | 1 | Chip enable, active low |
| oe_ni | input | 1 | Output enable, active low |
| we_ni | input | 1 | Write enable, active low |
| addr_i | input | ADDR_W | Byte address |
| data_i | input | DATA_W | Write data |
| data_o | output | DATA_W | Read data, zero when not driven |
| data_oe_o | output | 1 | Data bus drive enable |
| store_n_i | input | 1 | Store request, active low, sampled in idle |
| busy_no | output | 1 | Low while a transfer runs |
| pwr_good_i | input | 1 | Supply good; its rise starts a RECALL |
| pwr_fail_i | input | 1 | Supply failing; starts a STORE |
| status_o | output | 2 | 0 idle, 1 store-busy, 2 recall-busy |

## Verification
The sixth read of a software sequence can land in the same cycle as a hardware request. The bench provokes this in two ways. First, it raises pwr_fail_i on the very read that names the RECALL address. Second, it pulls store_n_i low in the cycle pwr_good_i rises. In each case status_o is judged in the first busy cycle, and a later RECALL and read-back shows which copy direction actually took place.

// File: rtl/nvsram_pkg.sv
`timescale 1ns/1ps
package nvsram_pkg;
  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_STORE  = 2'd1,
    ST_RECALL = 2'd2
  } nv_status_e;

  typedef enum logic [1:0] {
    F_IDLE,
    F_STORE,
    F_CLR,
    F_COPY
  } xfer_fsm_e;
endpackage

// File: rtl/nvsram_seq_detect.sv
`timescale 1ns/1ps
module nvsram_seq_detect #(
  parameter int ADDR_W      = 8,
  parameter int SEQ_ADDR [5] = '{'h0E, 'h38, 'hC7, 'h1F, 'hE0},
  parameter int STORE_ADDR  = 'h3C,
  parameter int RECALL_ADDR = 'h4C
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              rd_i,
  input  logic              wr_i,
  input  logic              flush_i,
  input  logic [ADDR_W-1:0] addr_i,
  output logic              sw_store_o,
  output logic              sw_recall_o
);
  localparam int STEPS = 5;

  logic [2:0]        idx_q;
  logic [ADDR_W-1:0] exp_addr;
  logic              last, first_hit;

  always_comb begin
    exp_addr = '0;
    for (int i = 0; i < STEPS; i++)
      if (idx_q == 3'(i)) exp_addr = ADDR_W'(SEQ_ADDR[i]);
  end

  assign last        = (idx_q == 3'(STEPS));
  assign first_hit   = (addr_i == ADDR_W'(SEQ_ADDR[0]));
  assign sw_store_o  = rd_i && last && (addr_i == ADDR_W'(STORE_ADDR));
  assign sw_recall_o = rd_i && last && (addr_i == ADDR_W'(RECALL_ADDR));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              idx_q <= '0;
    else if (flush_i || wr_i) idx_q <= '0;
    else if (rd_i) begin
      if (!last && addr_i == exp_addr) idx_q <= idx_q + 3'd1;
      else if (first_hit)              idx_q <= 3'd1;  // restart on a fresh first step
      else                             idx_q <= '0;
    end
  end
endmodule

// File: rtl/nvsram_xfer_ctrl.sv
`timescale 1ns/1ps
module nvsram_xfer_ctrl
  import nvsram_pkg::*;
#(
  parameter int STORE_CYCLES  = 40,
  parameter int RECALL_CYCLES = 12
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       pwr_fail_i,
  input  logic       pwr_good_i,
  input  logic       store_n_i,
  input  logic       sw_store_i,
  input  logic       sw_recall_i,
  output logic [1:0] status_o,
  output logic       start_o,
  output logic       snap_o,
  output logic       clear_o,
  output logic       load_o
);
  localparam int MAX_CYC = (STORE_CYCLES > RECALL_CYCLES) ? STORE_CYCLES : RECALL_CYCLES;
  localparam int CW      = $clog2(MAX_CYC + 1);

  xfer_fsm_e fsm_q;
  logic [CW-1:0] cnt_q;
  logic pg_q, pg_rise, idle, go_store, go_recall;

  assign idle      = (fsm_q == F_IDLE);
  assign pg_rise   = pwr_good_i && !pg_q;
  // priority: power fail, power-good rise, store pin, software sequence
  assign go_store  = idle && (pwr_fail_i || (!pg_rise && (!store_n_i || sw_store_i)));
  assign go_recall = idle && !pwr_fail_i && (pg_rise || (store_n_i && sw_recall_i));
  assign start_o   = go_store || go_recall;
  assign snap_o    = go_store;
  assign clear_o   = (fsm_q == F_CLR);
  assign load_o    = (fsm_q == F_COPY) && (cnt_q == CW'(1));

  always_comb begin
    unique case (fsm_q)
      F_IDLE:  status_o = ST_IDLE;
      F_STORE: status_o = ST_STORE;
      default: status_o = ST_RECALL;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      fsm_q <= F_IDLE;
      cnt_q <= '0;
      pg_q  <= 1'b0;
    end else begin
      pg_q <= pwr_good_i;
      unique case (fsm_q)
        F_IDLE: begin
          cnt_q <= '0;
          if (go_store)       fsm_q <= F_STORE;
          else if (go_recall) fsm_q <= F_CLR;
        end
        F_STORE: begin
          if (cnt_q == CW'(STORE_CYCLES - 1)) fsm_q <= F_IDLE;
          else cnt_q <= cnt_q + 1'b1;
        end
        F_CLR: begin
          fsm_q <= F_COPY;
          cnt_q <= cnt_q + 1'b1;
        end
        default: begin
          if (cnt_q == CW'(RECALL_CYCLES - 1)) fsm_q <= F_IDLE;
          else cnt_q <= cnt_q + 1'b1;
        end
      endcase
    end
  end
endmodule

// File: rtl/nvsram_cell_array.sv
`timescale 1ns/1ps
module nvsram_cell_array #(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              snap_i,
  input  logic              clear_i,
  input  logic              load_i,
  output logic [DATA_W-1:0] rdata_o
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] sram   [DEPTH];
  logic [DATA_W-1:0] shadow [DEPTH];

  assign rdata_o = sram[addr_i];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     for (int i = 0; i < DEPTH; i++) shadow[i] <= '0;
    else if (snap_i) shadow <= sram;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       for (int i = 0; i < DEPTH; i++) sram[i] <= '0;
    else if (clear_i)  for (int i = 0; i < DEPTH; i++) sram[i] <= '0;
    else if (load_i)   sram <= shadow;
    else if (wr_en_i)  sram[addr_i] <= wdata_i;
  end
endmodule

// File: rtl/nvsram_shadow.sv
`timescale 1ns/1ps
module nvsram_shadow
  import nvsram_pkg::*;
#(
  parameter int ADDR_W        = 8,
  parameter int DATA_W        = 8,
  parameter int STORE_CYCLES  = 40,
  parameter int RECALL_CYCLES = 12,
  parameter int SEQ_ADDR [5]  = '{'h0E, 'h38, 'hC7, 'h1F, 'hE0},
  parameter int STORE_ADDR    = 'h3C,
  parameter int RECALL_ADDR   = 'h4C
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ce_ni,
  input  logic              oe_ni,
  input  logic              we_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] data_i,
  output logic [DATA_W-1:0] data_o,
  output logic              data_oe_o,
  input  logic              store_n_i,
  output logic              busy_no,
  input  logic              pwr_good_i,
  input  logic              pwr_fail_i,
  output logic [1:0]        status_o
);
  logic idle, rd_acc, wr_acc, start, snap, clear, load;
  logic sw_store, sw_recall;
  logic [DATA_W-1:0] rdata;

  assign idle      = (status_o == ST_IDLE);
  assign rd_acc    = idle && !ce_ni && we_ni;
  assign wr_acc    = idle && !ce_ni && !we_ni;
  assign data_oe_o = rd_acc && !oe_ni;
  assign data_o    = data_oe_o ? rdata : '0;
  assign busy_no   = idle;

  nvsram_seq_detect #(
    .ADDR_W(ADDR_W), .SEQ_ADDR(SEQ_ADDR),
    .STORE_ADDR(STORE_ADDR), .RECALL_ADDR(RECALL_ADDR)
  ) u_seq (
    .clk_i, .rst_ni,
    .rd_i(rd_acc), .wr_i(wr_acc), .flush_i(start), .addr_i,
    .sw_store_o(sw_store), .sw_recall_o(sw_recall)
  );

  nvsram_xfer_ctrl #(
    .STORE_CYCLES(STORE_CYCLES), .RECALL_CYCLES(RECALL_CYCLES)
  ) u_ctrl (
    .clk_i, .rst_ni, .pwr_fail_i, .pwr_good_i, .store_n_i,
    .sw_store_i(sw_store), .sw_recall_i(sw_recall),
    .status_o, .start_o(start), .snap_o(snap), .clear_o(clear), .load_o(load)
  );

  nvsram_cell_array #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_array (
    .clk_i, .rst_ni,
    .wr_en_i(wr_acc && !start), .addr_i, .wdata_i(data_i),
    .snap_i(snap), .clear_i(clear), .load_i(load), .rdata_o(rdata)
  );
endmodule

// File: rtl/nvsram_shadow_chk.sv
`timescale 1ns/1ps
module nvsram_shadow_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       pwr_fail_i,
  input logic       pwr_good_i,
  input logic       store_n_i,
  input logic       data_oe_o,
  input logic       busy_no,
  input logic [1:0] status_o
);
  a_r9_locked_when_busy: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (status_o != 2'd0) |-> (!data_oe_o && !busy_no));

  a_r6_fail_starts_store: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (status_o == 2'd0 && pwr_fail_i) |=> (status_o == 2'd1));

  a_r5_good_rise_recall: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (status_o == 2'd0 && !pwr_fail_i && $rose(pwr_good_i)) |=> (status_o == 2'd2));

  a_r7_pin_starts_store: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (status_o == 2'd0 && !pwr_fail_i && !store_n_i && $stable(pwr_good_i) && $past(rst_ni))
    |=> (status_o == 2'd1));

  a_r10_store_ends_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (status_o == 2'd1) |=> (status_o != 2'd2));
endmodule

bind nvsram_shadow nvsram_shadow_chk u_chk (.*);

// File: tb/nvsram_shadow_test.sv
`timescale 1ns/1ps
module nvsram_shadow_test;
  localparam int STORE_CYC = 40;
  localparam int RECALL_CYC = 12;
  localparam int SEQ [5] = '{'h0E, 'h38, 'hC7, 'h1F, 'hE0};
  localparam int A_STORE = 'h3C;
  localparam int A_RECALL = 'h4C;

  logic clk = 0, rst_n = 0;
  logic ce_n = 1, oe_n = 1, we_n = 1, st_n = 1, pg = 0, pf = 0;
  logic [7:0] addr = '0, din = '0, dout;
  logic doe, busy_n;
  logic [1:0] status;

  nvsram_shadow uut (
    .clk_i(clk), .rst_ni(rst_n), .ce_ni(ce_n), .oe_ni(oe_n), .we_ni(we_n),
    .addr_i(addr), .data_i(din), .data_o(dout), .data_oe_o(doe),
    .store_n_i(st_n), .busy_no(busy_n), .pwr_good_i(pg), .pwr_fail_i(pf),
    .status_o(status)
  );

  always #5 clk = ~clk;

  typedef struct { logic oe; logic [7:0] d; string tag; } item_t;
  item_t q[$];
  logic pend = 0;
  int n_chk = 0, n_fail = 0;
  bit done = 0;
  logic [7:0] m_sram [256];
  logic [7:0] m_shadow [256];

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  task automatic finish_up();
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  endtask

  // monitor: pop expected read results
  always @(negedge clk) begin
    #2;
    if (pend) begin
      item_t it;
      pend = 0;
      it = q.pop_front();
      chk(doe == it.oe && (!it.oe || dout == it.d), it.tag,
          {23'd0, doe, dout}, {23'd0, it.oe, it.d});
    end
  end

  task automatic rest(input int n);
    repeat (n) begin
      @(negedge clk);
      ce_n = 1; we_n = 1; oe_n = 1; st_n = 1; pf = 0;
    end
  endtask

  task automatic rd(input int a, input string tag);
    @(negedge clk);
    ce_n = 0; we_n = 1; oe_n = 0; addr = 8'(a);
    q.push_back('{1'b1, m_sram[a], tag}); pend = 1;
  endtask

  task automatic rd_off(input int a, input string tag);  // expect no drive
    @(negedge clk);
    ce_n = 0; we_n = 1; oe_n = 0; addr = 8'(a);
    q.push_back('{1'b0, 8'h00, tag}); pend = 1;
  endtask

  task automatic wr(input int a, input logic [7:0] d, input bit takes);
    @(negedge clk);
    ce_n = 0; we_n = 0; oe_n = 1; addr = 8'(a); din = d;
    if (takes) m_sram[a] = d;
  endtask

  task automatic prefix(input int upto);
    for (int i = 0; i < upto; i++) rd(SEQ[i], "R2 sequence read");
  endtask

  task automatic busy_count(input int exp_st, input int n0, input string tag, output int n);
    bit seen = 0;
    n = n0;
    for (int k = 0; k < 400; k++) begin
      @(negedge clk);
      ce_n = 1; we_n = 1; oe_n = 1; st_n = 1; pf = 0;
      #1;
      if (!busy_n) begin
        if (!seen) chk(status == 2'(exp_st), tag, status, exp_st);
        seen = 1;
        n++;
      end else if (seen || k > 2) break;
    end
  endtask

  task automatic do_store_model(); m_shadow = m_sram; endtask
  task automatic do_recall_model(); m_sram = m_shadow; endtask

  initial begin
    #(200000 * 10);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired actual=0x0 expected=0x1");
    finish_up();
  end

  initial begin
    int n;
    for (int i = 0; i < 256; i++) begin m_sram[i] = 0; m_shadow[i] = 0; end
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk); #1;
    chk(status == 2'd0 && busy_n == 1'b1 && doe == 1'b0, "R11 reset state",
        {status, busy_n, doe}, 4'b0010);

    // R5: power-good rise -> recall
    pg = 1;
    busy_count(2, 0, "R5 power-good rise gives recall", n);
    chk(n == RECALL_CYC, "R10 recall length", n, RECALL_CYC);
    do_recall_model();

    // R1: write/read patterns
    for (int i = 0; i < 8; i++) wr('h10 + i, 8'(i * 'h11 + 3), 1);
    wr('h00, 8'hFF, 1); wr('hFF, 8'h81, 1);
    for (int i = 0; i < 8; i++) rd('h10 + i, "R1 read back");
    rd('h00, "R1 read addr 0"); rd('hFF, "R1 read top addr");
    @(negedge clk); ce_n = 0; we_n = 1; oe_n = 1; addr = 8'h10;
    q.push_back('{1'b0, 8'h00, "R1 oe high no drive"}); pend = 1;
    rest(1);

    // R2: software store, with blocked access during busy (R9)
    prefix(5); rd(A_STORE, "R2 final store read");
    do_store_model();
    rd_off('h10, "R9 read blocked in store");
    wr('h10, 8'h55, 0);
    busy_count(1, 2, "R2 software store status", n);
    chk(n == STORE_CYC, "R10 store length", n, STORE_CYC);
    rd('h10, "R9 write dropped during store");

    // overwrite after store
    for (int i = 0; i < 8; i++) wr('h10 + i, 8'(8'hA0 + i), 1);
    wr('h20, 8'h99, 1);

    // R3: abort by write
    prefix(3); wr('h20, 8'h66, 1); rd(SEQ[3], "R3 seq"); rd(SEQ[4], "R3 seq");
    rd(A_STORE, "R3 final after write");
    rest(1); #1;
    chk(status == 2'd0, "R3 write abort keeps idle", status, 0);
    // R3: abort by stray read
    prefix(4); rd('h21, "R3 stray read"); rd(SEQ[4], "R3 seq");
    rd(A_RECALL, "R3 final after stray");
    rest(1); #1;
    chk(status == 2'd0, "R3 stray read abort keeps idle", status, 0);
    rd('h20, "R3 array holds last write");
    rest(1);

    // R4: software recall restores stored image; aborted attempts stored nothing
    prefix(5); rd(A_RECALL, "R2 final recall read");
    busy_count(2, 0, "R2 software recall status", n);
    do_recall_model();
    for (int i = 0; i < 8; i++) rd('h10 + i, "R4 recall restores");
    rd('h20, "R3 shadow untouched by aborted sequence");
    // R4 repeat
    wr('h11, 8'h00, 1); rest(1);
    prefix(5); rd(A_RECALL, "R4 second recall read");
    busy_count(2, 0, "R4 repeat recall status", n);
    do_recall_model();
    rd('h11, "R4 repeated recall same data");
    rd('h00, "R4 repeated recall addr 0");

    // R7: store pin
    wr('h30, 8'hA5, 1);
    @(negedge clk); ce_n = 1; we_n = 1; st_n = 0;
    do_store_model();
    busy_count(1, 0, "R7 store pin gives store", n);
    wr('h30, 8'h00, 1); rest(1);
    prefix(5); rd(A_RECALL, "R7 recall read");
    busy_count(2, 0, "R7 recall status", n);
    do_recall_model();
    rd('h30, "R7 pin store saved byte");

    // R6: power fail
    wr('h31, 8'h3C, 1);
    @(negedge clk); ce_n = 1; we_n = 1; pf = 1;
    do_store_model();
    busy_count(1, 0, "R6 power fail gives store", n);
    chk(n == STORE_CYC, "R10 power-fail store length", n, STORE_CYC);
    wr('h31, 8'h00, 1);
    @(negedge clk); ce_n = 1; pg = 0;
    @(negedge clk); pg = 1;
    busy_count(2, 0, "R5 second power-good rise", n);
    do_recall_model();
    rd('h31, "R6 power fail store saved byte");

    // R8: power fail on the final recall read -> store wins
    wr('h32, 8'h77, 1);
    prefix(5);
    @(negedge clk); ce_n = 0; we_n = 1; oe_n = 0; addr = 8'(A_RECALL); pf = 1;
    q.push_back('{1'b1, m_sram[A_RECALL], "R8 final read with power fail"}); pend = 1;
    do_store_model();
    busy_count(1, 0, "R8 power fail beats software recall", n);
    wr('h32, 8'h00, 1); rest(1);
    prefix(5); rd(A_RECALL, "R8 recall read");
    busy_count(2, 0, "R8 recall status", n);
    do_recall_model();
    rd('h32, "R8 store direction taken");

    // R8: power-good rise together with store pin -> recall wins
    wr('h33, 8'h5A, 1);
    @(negedge clk); ce_n = 1; pg = 0;
    @(negedge clk); pg = 1; st_n = 0;
    busy_count(2, 0, "R8 power-good rise beats store pin", n);
    do_recall_model();
    rd('h33, "R8 recall direction taken");

    // R8: write in a start cycle is dropped
    @(negedge clk); ce_n = 0; we_n = 0; oe_n = 1; addr = 8'h34; din = 8'hEE; st_n = 0;
    do_store_model();
    busy_count(1, 0, "R8 store with same-cycle write", n);
    rd('h34, "R8 same-cycle write dropped");
    rest(2);
    finish_up();
  end
endmodule